// File: doc/BRIEF.md
# Quiz Round and Scoring Controller

This block referees a buzzer quiz for eight contestants, numbered 1 to 8. A host computer starts each round by sending the byte 'k' over a serial receive path. The block then arms the contestant buttons and keeps only the first rising press. Every other button is shut out until the host clears the round. The block announces the responder by requesting a transmit byte with that contestant's ASCII digit. A lamp stays lit while that contestant holds the right to answer.

Two windows are counted in seconds from a one-second tick input. The competition window runs from arming until somebody presses. The answer window runs from the press until the host gives a verdict. A host verdict of correct adds one point to the responder's signed 8-bit score. A wrong verdict, or a verdict that comes too late, takes one point away. A contestant whose score goes below zero is eliminated, and that contestant's button is masked for the rest of the game. When the window limits expire, a timeout lamp lights. When the host sends 'e', the block reports the highest-scoring contestant.

Top module: `quiz_round_ctrl`

## Requirements
- R1: While the controller is idle (no round started), button presses change no output: the hold lamp stays 0 and no transmit byte is requested.
- R2: Only a received byte equal to 0x6B ('k') starts a round. Any other received byte leaves the controller idle, so presses stay ignored.
- R3: The first rising button edge after arming latches that contestant. responder_o becomes the contestant number (1..8), hold_lamp_o goes to 1, and a one-cycle transmit request carries the byte 0x30 plus the number. All of this happens on the clock edge that samples the press.
- R4: Once a responder is latched, further presses leave responder_o unchanged until the host clears the round.
- R5: If several armed buttons rise in the same cycle, the lowest-numbered contestant is latched.
- R6: If nobody presses before the competition limit expires, the following happens on the tick that completes the limit: timeout_lamp_o goes to 1, a one-cycle transmit request carries 0x54 ('T'), and no score changes.
- R7: A correct verdict adds 1 to the responder's score and a wrong verdict subtracts 1. Scores are 8-bit two's complement values, and contestant n sits at scores_o bits [8n-1:8n-8]. Only one score changes per round.
- R8: If no verdict arrives before the answer limit expires, timeout_lamp_o goes to 1 on the tick that completes the limit, hold_lamp_o drops, and the responder loses 1 point.
- R9: A contestant whose score drops below zero gets elim_o bit n-1 set. That bit never clears, and the contestant's button is ignored in every later round.
- R10: A received 0x65 ('e') while idle or armed sets winner_o to the highest-scoring contestant (the lowest number on a tie) and sets winner_valid_o. The same byte received after a round has ended and before it is cleared has no effect.
- R11: After reset, all scores are 0, all lamps and flags are 0, and both window limits are 10 seconds.
- R12: A pulse on cfg_load_i loads new competition and answer limits, in seconds, from cfg_comp_i and cfg_ans_i.
- R13: After a round ends, clear_i returns the controller to idle and turns the timeout lamp off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 8 | Debounced contestant buttons, bit n-1 for contestant n |
| rx_valid_i | input | 1 | Received-byte strobe |
| rx_byte_i | input | 8 | Received byte |
| cfg_load_i | input | 1 | Load both window limits |
| cfg_comp_i | input | 8 | Competition window, seconds |
| cfg_ans_i | input | 8 | Answer window, seconds |
| tick_i | input | 1 | One-cycle pulse per second |
| verdict_valid_i | input | 1 | Host verdict strobe |
| verdict_ok_i | input | 1 | 1 = correct, 0 = wrong |
| clear_i | input | 1 | Host clears a finished round |
| tx_valid_o | output | 1 | Transmit-byte request, one cycle |
| tx_byte_o | output | 8 | Byte to transmit |
| timeout_lamp_o | output | 1 | A window limit expired |
| hold_lamp_o | output | 1 | A contestant holds the answer right |
| responder_o | output | 4 | Latched contestant number, 0 if none |
| winner_o | output | 4 | Highest-scoring contestant |
| winner_valid_o | output | 1 | winner_o is valid |
| scores_o | output | 64 | Eight signed 8-bit scores |
| elim_o | output | 8 | Elimination flags |

## Verification
The first-press logic is driven with single presses, with presses that arrive after a contestant is already latched, with two buttons rising in the same cycle, and with presses from eliminated contestants. These cases separate a correct lockout from a wrong priority or from a mask that does not work. Ticks are counted one at a time around each window limit, both at the default and at a loaded value, so that an off-by-one expiry shows up. Random rounds then mix correct, wrong and late answers over contestants who are still in the game. A bench model keeps its own scores, and at the end the reported winner is compared with the model's choice, which covers tie handling.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ANSWERING,
    ST_SCORE,
    ST_DONE
  } round_state_t;

  localparam logic [7:0] CMD_START  = 8'h6B;
  localparam logic [7:0] CMD_END    = 8'h65;
  localparam logic [7:0] TX_TIMEOUT = 8'h54;
  localparam logic [7:0] TX_DIGIT0  = 8'h30;
endpackage

// File: rtl/quiz_first_press.sv
module quiz_first_press #(
  parameter int N    = 8,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    btn,
  input  logic [N-1:0]    mask,
  input  logic            enable,
  output logic            hit,
  output logic [ID_W-1:0] hit_id
);
  logic [N-1:0] btn_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= '0;
    else     btn_q <= btn;
  end

  assign rise = btn & ~btn_q & ~mask;
  assign hit  = enable && (|rise);

  // scan from the top so the lowest index is assigned last and wins
  always_comb begin
    hit_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rise[i]) hit_id = ID_W'(i + 1);
    end
  end
endmodule

// File: rtl/quiz_window_timer.sv
module quiz_window_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] limit,
  input  logic          tick,
  output logic          expire
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= limit;
    else if (tick && cnt != '0) cnt <= cnt - LW'(1);
  end

  assign expire = tick && !load && ((cnt == '0) || (cnt == LW'(1)));
endmodule

// File: rtl/quiz_scoreboard.sv
module quiz_scoreboard #(
  parameter int N    = 8,
  parameter int SW   = 8,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            apply,
  input  logic [ID_W-1:0] apply_id,
  input  logic            apply_up,
  output logic [N*SW-1:0] scores,
  output logic [N-1:0]    elim,
  output logic [ID_W-1:0] best_id
);
  localparam logic signed [SW-1:0] SCORE_MAX = {1'b0, {(SW-1){1'b1}}};

  logic signed [SW-1:0] score [N];

  for (genvar g = 0; g < N; g++) begin : g_player
    always_ff @(posedge clk) begin
      if (rst) begin
        score[g] <= '0;
        elim[g]  <= 1'b0;
      end else if (apply && apply_id == ID_W'(g + 1)) begin
        if (apply_up) begin
          if (score[g] != SCORE_MAX) score[g] <= score[g] + SW'(1);
        end else begin
          score[g] <= score[g] - SW'(1);
          if (score[g] == '0) elim[g] <= 1'b1;
        end
      end
    end
    assign scores[g*SW +: SW] = score[g];
  end

  always_comb begin
    logic signed [SW-1:0] top;
    top     = score[0];
    best_id = ID_W'(1);
    for (int i = 1; i < N; i++) begin
      if (score[i] > top) begin
        top     = score[i];
        best_id = ID_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/quiz_round_ctrl.sv
module quiz_round_ctrl
  import quiz_pkg::*;
#(
  parameter int NUM_PLAYERS = 8,
  parameter int SCORE_W     = 8,
  parameter int LIMIT_W     = 8,
  parameter int DEF_COMP    = 10,
  parameter int DEF_ANS     = 10,
  localparam int ID_W       = $clog2(NUM_PLAYERS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PLAYERS-1:0]     btn_i,
  input  logic                       rx_valid_i,
  input  logic [7:0]                 rx_byte_i,
  input  logic                       cfg_load_i,
  input  logic [LIMIT_W-1:0]         cfg_comp_i,
  input  logic [LIMIT_W-1:0]         cfg_ans_i,
  input  logic                       tick_i,
  input  logic                       verdict_valid_i,
  input  logic                       verdict_ok_i,
  input  logic                       clear_i,
  output logic                       tx_valid_o,
  output logic [7:0]                 tx_byte_o,
  output logic                       timeout_lamp_o,
  output logic                       hold_lamp_o,
  output logic [ID_W-1:0]            responder_o,
  output logic [ID_W-1:0]            winner_o,
  output logic                       winner_valid_o,
  output logic [NUM_PLAYERS*SCORE_W-1:0] scores_o,
  output logic [NUM_PLAYERS-1:0]     elim_o
);
  round_state_t        state;
  logic [LIMIT_W-1:0]  comp_lim, ans_lim;
  logic                hit, expire, tmr_load;
  logic [ID_W-1:0]     hit_id, best_id;
  logic                sc_apply, sc_up;
  logic                got_start, got_end;

  assign got_start = rx_valid_i && rx_byte_i == CMD_START;
  assign got_end   = rx_valid_i && rx_byte_i == CMD_END;
  assign tmr_load  = (state == ST_IDLE && got_start) || (state == ST_ARMED && hit);

  quiz_first_press #(.N(NUM_PLAYERS), .ID_W(ID_W)) u_press (
    .clk(clk), .rst(rst), .btn(btn_i), .mask(elim_o),
    .enable(state == ST_ARMED), .hit(hit), .hit_id(hit_id)
  );

  quiz_window_timer #(.LW(LIMIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load),
    .limit(state == ST_IDLE ? comp_lim : ans_lim),
    .tick(tick_i), .expire(expire)
  );

  quiz_scoreboard #(.N(NUM_PLAYERS), .SW(SCORE_W), .ID_W(ID_W)) u_score (
    .clk(clk), .rst(rst), .apply(sc_apply), .apply_id(responder_o),
    .apply_up(sc_up), .scores(scores_o), .elim(elim_o), .best_id(best_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      comp_lim       <= LIMIT_W'(DEF_COMP);
      ans_lim        <= LIMIT_W'(DEF_ANS);
      tx_valid_o     <= 1'b0;
      tx_byte_o      <= '0;
      timeout_lamp_o <= 1'b0;
      hold_lamp_o    <= 1'b0;
      responder_o    <= '0;
      winner_o       <= '0;
      winner_valid_o <= 1'b0;
      sc_apply       <= 1'b0;
      sc_up          <= 1'b0;
    end else begin
      tx_valid_o <= 1'b0;
      sc_apply   <= 1'b0;
      if (cfg_load_i) begin
        comp_lim <= cfg_comp_i;
        ans_lim  <= cfg_ans_i;
      end
      unique case (state)
        ST_IDLE: begin
          if (got_start) begin
            state          <= ST_ARMED;
            timeout_lamp_o <= 1'b0;
            responder_o    <= '0;
          end else if (got_end) begin
            winner_o       <= best_id;
            winner_valid_o <= 1'b1;
          end
        end
        ST_ARMED: begin
          if (hit) begin
            responder_o <= hit_id;
            hold_lamp_o <= 1'b1;
            tx_valid_o  <= 1'b1;
            tx_byte_o   <= TX_DIGIT0 + 8'(hit_id);
            state       <= ST_ANSWERING;
          end else if (got_end) begin
            winner_o       <= best_id;
            winner_valid_o <= 1'b1;
            state          <= ST_IDLE;
          end else if (expire) begin
            timeout_lamp_o <= 1'b1;
            tx_valid_o     <= 1'b1;
            tx_byte_o      <= TX_TIMEOUT;
            state          <= ST_DONE;
          end
        end
        ST_ANSWERING: begin
          if (verdict_valid_i) begin
            sc_apply    <= 1'b1;
            sc_up       <= verdict_ok_i;
            hold_lamp_o <= 1'b0;
            state       <= ST_SCORE;
          end else if (expire) begin
            sc_apply       <= 1'b1;
            sc_up          <= 1'b0;
            hold_lamp_o    <= 1'b0;
            timeout_lamp_o <= 1'b1;
            state          <= ST_SCORE;
          end
        end
        ST_SCORE: state <= ST_DONE;
        ST_DONE: begin
          if (clear_i) begin
            state          <= ST_IDLE;
            timeout_lamp_o <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/quiz_round_ctrl_chk.sv
module quiz_round_ctrl_chk #(
  parameter int N    = 8,
  parameter int SW   = 8,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            tx_valid_o,
  input logic            hold_lamp_o,
  input logic [ID_W-1:0] responder_o,
  input logic [ID_W-1:0] winner_o,
  input logic            winner_valid_o,
  input logic [N*SW-1:0] scores_o,
  input logic [N-1:0]    elim_o
);
  logic [N*SW-1:0] prev_scores;
  logic [N-1:0]    changed;

  always_ff @(posedge clk) prev_scores <= scores_o;

  for (genvar g = 0; g < N; g++) begin : g_chg
    assign changed[g] = scores_o[g*SW +: SW] != prev_scores[g*SW +: SW];
  end

  assert_responder_range_R3: assert property (@(posedge clk) disable iff (rst)
    hold_lamp_o |-> (responder_o >= ID_W'(1) && responder_o <= ID_W'(N)));

  assert_tx_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |=> !tx_valid_o);

  assert_responder_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_lamp_o && $past(hold_lamp_o)) |-> $stable(responder_o));

  assert_one_score_moves_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(changed) <= 1);

  assert_elim_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (|elim_o) |=> ((elim_o & $past(elim_o)) == $past(elim_o)));

  assert_winner_range_R10: assert property (@(posedge clk) disable iff (rst)
    winner_valid_o |-> (winner_o >= ID_W'(1) && winner_o <= ID_W'(N)));
endmodule

bind quiz_round_ctrl quiz_round_ctrl_chk #(
  .N(NUM_PLAYERS), .SW(SCORE_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst(rst), .tx_valid_o(tx_valid_o), .hold_lamp_o(hold_lamp_o),
  .responder_o(responder_o), .winner_o(winner_o), .winner_valid_o(winner_valid_o),
  .scores_o(scores_o), .elim_o(elim_o)
);

// File: tb/tb_quiz_round_ctrl.sv
module tb_quiz_round_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  btn_i = '0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [7:0]  cfg_comp_i = '0, cfg_ans_i = '0;
  logic        tick_i = 1'b0, verdict_valid_i = 1'b0, verdict_ok_i = 1'b0, clear_i = 1'b0;
  logic        tx_valid_o, timeout_lamp_o, hold_lamp_o, winner_valid_o;
  logic [7:0]  tx_byte_o, elim_o;
  logic [3:0]  responder_o, winner_o;
  logic [63:0] scores_o;

  int total = 0, bad = 0;
  int model [1:8];
  bit done_flag = 0;
  logic cap_tx, cap_hold, cap_lamp;
  logic [7:0] cap_byte;
  logic [3:0] cap_resp;

  always #5 clk = ~clk;

  quiz_round_ctrl dut (.*);

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int score_of(int p);
    return int'($signed(scores_o[8*(p-1) +: 8]));
  endfunction

  function automatic int exp_winner();
    int best = 1;
    for (int p = 2; p <= 8; p++) if (model[p] > model[best]) best = p;
    return best;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic capture();
    cap_tx = tx_valid_o; cap_byte = tx_byte_o; cap_hold = hold_lamp_o;
    cap_lamp = timeout_lamp_o; cap_resp = responder_o;
  endtask

  task automatic send(logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b; cyc(); capture(); rx_valid_i = 1'b0;
  endtask

  task automatic press(logic [7:0] m);
    btn_i = m; cyc(); capture(); btn_i = '0; cyc();
  endtask

  task automatic tick();
    tick_i = 1'b1; cyc(); capture(); tick_i = 1'b0;
  endtask

  task automatic verdict(bit ok);
    verdict_valid_i = 1'b1; verdict_ok_i = ok; cyc();
    verdict_valid_i = 1'b0; cyc();
  endtask

  task automatic clear_round();
    clear_i = 1'b1; cyc(); clear_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 1; p <= 8; p++) model[p] = 0;
    repeat (3) cyc();
    rst = 1'b0; cyc();
    // R11 reset state
    check(scores_o == 64'd0 && elim_o == 8'd0, "R11", "scores", int'(scores_o[31:0]), 0);
    check(!timeout_lamp_o && !hold_lamp_o && !winner_valid_o && responder_o == 0,
          "R11", "flags", int'(timeout_lamp_o), 0);
    // R1 idle press ignored
    press(8'h04);
    check(!cap_hold && !cap_tx, "R1", "idle press hold", int'(cap_hold), 0);
    // R2 wrong byte does not arm
    send(8'h78);
    press(8'h04);
    check(!cap_hold && !cap_tx, "R2", "press after non-start byte", int'(cap_hold), 0);
    // R6/R11 default competition window 10 s
    send(8'h6B);
    for (int i = 0; i < 9; i++) tick();
    check(!cap_lamp, "R11", "lamp after 9 ticks", int'(cap_lamp), 0);
    tick();
    check(cap_lamp, "R6", "lamp after 10 ticks", int'(cap_lamp), 1);
    check(cap_tx && cap_byte == 8'h54, "R6", "timeout byte", int'(cap_byte), 8'h54);
    check(scores_o == 64'd0, "R6", "no score change", int'(scores_o[31:0]), 0);
    // R10 end ignored after round ended
    send(8'h65);
    check(!winner_valid_o, "R10", "end ignored when done", int'(winner_valid_o), 0);
    clear_round();
    check(!timeout_lamp_o, "R13", "lamp cleared", int'(timeout_lamp_o), 0);
    // R12 loaded limits
    cfg_comp_i = 8'd3; cfg_ans_i = 8'd2; cfg_load_i = 1'b1; cyc(); cfg_load_i = 1'b0;
    send(8'h6B);
    tick(); tick();
    check(!cap_lamp, "R12", "lamp after 2 of 3", int'(cap_lamp), 0);
    tick();
    check(cap_lamp, "R12", "lamp after 3 of 3", int'(cap_lamp), 1);
    clear_round();
    // R3/R4/R7 first press and correct answer
    send(8'h6B);
    press(8'h04);
    check(cap_resp == 3 && cap_hold, "R3", "responder", int'(cap_resp), 3);
    check(cap_tx && cap_byte == 8'h33, "R3", "digit byte", int'(cap_byte), 8'h33);
    press(8'h01);
    check(cap_resp == 3 && !cap_tx, "R4", "lockout", int'(cap_resp), 3);
    verdict(1'b1); model[3] = 1;
    check(score_of(3) == 1, "R7", "correct adds", score_of(3), 1);
    clear_round();
    // R5 simultaneous press, R9 elimination after wrong
    send(8'h6B);
    press(8'h12);
    check(cap_resp == 2, "R5", "lowest wins", int'(cap_resp), 2);
    verdict(1'b0); model[2] = -1;
    check(score_of(2) == -1, "R7", "wrong subtracts", score_of(2), -1);
    check(elim_o == 8'h02, "R9", "elim flag", int'(elim_o), 2);
    clear_round();
    // R9 masked button; R8 late answer
    send(8'h6B);
    press(8'h02);
    check(!cap_hold && !cap_tx, "R9", "eliminated press ignored", int'(cap_hold), 0);
    press(8'h08);
    check(cap_resp == 4, "R9", "others still buzz", int'(cap_resp), 4);
    tick();
    check(!cap_lamp && cap_hold, "R8", "before answer limit", int'(cap_lamp), 0);
    tick();
    check(cap_lamp && !cap_hold, "R8", "answer limit lamp", int'(cap_lamp), 1);
    cyc(); model[4] = -1;
    check(score_of(4) == -1 && elim_o == 8'h0A, "R8", "late penalty", score_of(4), -1);
    clear_round();
    send(8'h65);
    check(winner_valid_o && winner_o == 3, "R10", "winner directed", int'(winner_o), 3);
    // random rounds
    for (int r = 0; r < 40; r++) begin
      int p, alive, kind;
      alive = 0;
      for (int q = 1; q <= 8; q++) if (model[q] >= 0) alive++;
      do p = int'($urandom % 8) + 1; while (model[p] < 0);
      kind = int'($urandom % 3);
      if (kind != 0 && model[p] == 0 && alive <= 2) kind = 0;
      send(8'h6B);
      repeat ($urandom % 3) tick();
      press(8'(1 << (p - 1)));
      check(cap_resp == 4'(p), "R3", "random responder", int'(cap_resp), p);
      if (kind == 0) begin verdict(1'b1); model[p]++; end
      else if (kind == 1) begin verdict(1'b0); model[p]--; end
      else begin tick(); tick(); cyc(); model[p]--; end
      check(score_of(p) == model[p], "R7", "random score", score_of(p), model[p]);
      check(elim_o[p-1] == (model[p] < 0), "R9", "random elim", int'(elim_o[p-1]), int'(model[p] < 0));
      clear_round();
    end
    send(8'h65);
    check(winner_o == 4'(exp_winner()), "R10", "random winner", int'(winner_o), exp_winner());
    finish_run();
  end
endmodule